// File: doc/BRIEF.md
# HDB3/AMI Line Codec With Error Counter

This block sits between a framer's serial data stream and the pulse rails of an E1 line interface. In the transmit direction it takes one NRZ bit per bit-clock edge and produces positive and negative pulse rails. The pulses follow alternate mark inversion (AMI), or AMI with HDB3 zero substitution. Dual-rail system data can also be passed to the rails without coding. In the receive direction it turns the two pulse rails back into NRZ data and removes the HDB3 substitutions. It raises one error output for bipolar or code violations and for excess-zero runs, and a saturating counter totals those errors.

Everything runs on one fast system clock. The line bit clock `bit_clk` is sampled in that domain, and its rising or falling edge, as configured, gives a one-cycle bit strobe. All data inputs are sampled on that strobe and all outputs are registered on it. The error count is read through a latch strobe. The strobe copies the running count into a holding register and clears the count, so the low and high bytes always belong to one value.

Top module: `line_codec`

## Requirements
- R1: With `cfg_dual`=1 the transmit coder is bypassed. On each bit strobe the rails take (p=`tx_data`, n=`tx_neg`) after the level inversion of R4. p=1,n=0 gives a positive pulse (`tx_pos_out`=1), p=0,n=1 gives a negative pulse (`tx_neg_out`=1), and equal rails give a space. The outputs change one strobe later.
- R2: With `cfg_dual`=0 and `cfg_hdb3`=0 (AMI), every 1 bit becomes a pulse of the opposite polarity to the previous pulse, and 0 bits are spaces. The first pulse after reset is positive, and long zero runs stay spaces. A bit sampled at strobe k appears on the rails after strobe k+3.
- R3: With `cfg_hdb3`=1, each run of four zeros is replaced by 000V when an odd number of pulses has been sent since the last V, and by B00V when that number is even. B is a normal alternating pulse. V has the same polarity as the pulse before it.
- R4: `cfg_tx_inv`=1 inverts `tx_data` and `tx_neg` before they are used.
- R5: `cfg_fall_edge`=0 makes the rising edge of `bit_clk` the bit strobe, and `cfg_fall_edge`=1 makes the falling edge the strobe. The outputs change on no other edge.
- R6: With `cfg_dual`=0, a received pulse on either rail decodes to 1 and a space to 0. Both rails high counts as a space. Output `rx_data` shows the bit received at strobe k after strobe k+3. In HDB3 mode, a violation whose two preceding symbols are spaces is taken as a substitution. The violation and the symbol three places before it are both restored to 0.
- R7: In AMI mode, a pulse with the same polarity as the previous pulse is a bipolar violation. It sets `rx_err` and still decodes as 1.
- R8: In HDB3 mode, a violation that is not preceded by two spaces is a code violation and sets `rx_err`.
- R9: Once a first pulse has been received after reset, the zeros in a run are counted. The zero that brings the run to 4 (HDB3) or to 16 (AMI) sets `rx_err`, once per run.
- R10: `rx_err` is set or cleared on each bit strobe, so it holds one event for exactly one bit period. With `cfg_dual`=1, `rx_err` stays 0, `rx_data` shows the positive rail and `rx_neg_out` shows the negative rail.
- R11: `cfg_rx_inv`=1 inverts `rx_data` and `rx_neg_out`.
- R12: Every strobe that sets `rx_err` adds one to a 16-bit error count. The count saturates at 16'hFFFF.
- R13: A one-cycle pulse on `cnt_latch` copies the count to `cnt_hi`:`cnt_lo` and clears the count. The bytes hold their value until the next latch.
- R14: `tx_pos_out` and `tx_neg_out` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_clk | input | 1 | Line bit clock, sampled by clk |
| cfg_fall_edge | input | 1 | 1: falling edge of bit_clk is the strobe |
| cfg_dual | input | 1 | 1: dual-rail system data, coder bypassed |
| cfg_hdb3 | input | 1 | 1: HDB3, 0: AMI |
| cfg_tx_inv | input | 1 | Invert transmit system data |
| cfg_rx_inv | input | 1 | Invert receive system data |
| tx_data | input | 1 | NRZ data, or positive rail in dual mode |
| tx_neg | input | 1 | Negative rail in dual mode |
| tx_pos_out | output | 1 | Positive line pulse |
| tx_neg_out | output | 1 | Negative line pulse |
| rx_pos_in | input | 1 | Received positive pulse |
| rx_neg_in | input | 1 | Received negative pulse |
| rx_data | output | 1 | Decoded NRZ data, or positive rail in dual mode |
| rx_neg_out | output | 1 | Negative rail in dual mode, 0 otherwise |
| rx_err | output | 1 | Violation or excess-zero flag |
| cnt_latch | input | 1 | Latch and clear the error count |
| cnt_lo | output | 8 | Latched count, low byte |
| cnt_hi | output | 8 | Latched count, high byte |

## Verification
A wrong HDB3 parity or polarity register shows up as a wrong pulse polarity on the line three strobes after the offending bit. The bench connects transmit to receive, so the same fault also reaches `rx_data` four strobes later as a lost or extra 1. A wrong decoder pipe or zero-run count shows at once as a wrongly set or missing `rx_err` on the strobe that received the symbol. A fault in the counter only shows at the next latch, as wrong byte values.

// File: rtl/lc_pkg.sv
package lc_pkg;
  // one slot of the transmit look-ahead pipe
  typedef struct packed {
    logic vld;   // slot holds a real bit
    logic one;   // data bit is a mark
    logic v;     // slot was turned into a violation pulse
  } enc_slot_t;

  localparam int PIPE_STAGES = 3;
endpackage

// File: rtl/lc_bit_strobe.sv
module lc_bit_strobe (
  input  logic clk,
  input  logic rst,
  input  logic bit_clk,
  input  logic fall_sel,
  output logic strb
);
  logic bclk_q;

  always_ff @(posedge clk) begin
    bclk_q <= bit_clk;
  end

  // during reset the history simply follows the input, so no false edge
  always_comb begin
    if (rst)           strb = 1'b0;
    else if (fall_sel) strb = bclk_q & ~bit_clk;
    else               strb = bit_clk & ~bclk_q;
  end
endmodule

// File: rtl/lc_encoder.sv
module lc_encoder
  import lc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic strb,
  input  logic hdb3,
  input  logic dual,
  input  logic din,
  input  logic din_n,
  output logic pos_o,
  output logic neg_o
);
  localparam int STG = PIPE_STAGES;

  enc_slot_t pipe [STG];
  logic      par;       // pulses since last V, odd when 1
  logic      last_pos;  // polarity of the last pulse sent
  logic      run4, sub, mk_b, mk_v, mk_one, pulse, pol;
  enc_slot_t leave;

  always_comb begin
    run4 = hdb3 & ~din;
    for (int i = 0; i < STG; i++) begin
      run4 = run4 & pipe[i].vld & ~pipe[i].one & ~pipe[i].v;
    end
    sub    = run4;
    leave  = pipe[STG-1];
    mk_b   = sub & ~par;
    mk_v   = ~sub & leave.vld & leave.v;
    mk_one = ~sub & leave.vld & leave.one;
    pulse  = mk_b | mk_v | mk_one;
    pol    = mk_v ? last_pos : ~last_pos;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STG; i++) pipe[i] <= '0;
      pos_o    <= 1'b0;
      neg_o    <= 1'b0;
      par      <= 1'b0;
      last_pos <= 1'b0;
    end else if (strb) begin
      if (dual) begin
        pos_o <= din & ~din_n;
        neg_o <= din_n & ~din;
      end else begin
        for (int i = STG - 1; i > 0; i--) pipe[i] <= pipe[i-1];
        pipe[0] <= '{vld: 1'b1, one: din, v: sub};
        pos_o   <= pulse & pol;
        neg_o   <= pulse & ~pol;
        if (pulse) begin
          last_pos <= pol;
          par      <= mk_v ? 1'b0 : ~par;
        end
      end
    end
  end
endmodule

// File: rtl/lc_decoder.sv
module lc_decoder #(
  parameter int EXZ_HDB3 = 4,
  parameter int EXZ_AMI  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic strb,
  input  logic hdb3,
  input  logic dual,
  input  logic inv,
  input  logic rp,
  input  logic rn,
  output logic data_o,
  output logic neg_o,
  output logic err_o,
  output logic evt_o
);
  localparam int STG  = lc_pkg::PIPE_STAGES;
  localparam int ZMAX = (EXZ_HDB3 > EXZ_AMI) ? EXZ_HDB3 : EXZ_AMI;
  localparam int ZW   = $clog2(ZMAX + 1);

  logic [STG-1:0] dpipe;
  logic           seen, last_pos;
  logic [ZW-1:0]  zc, thr;
  logic           mark, viol, sub, cv, exz;

  always_comb begin
    mark = rp ^ rn;
    viol = mark & seen & (rp == last_pos);
    sub  = hdb3 & viol & ~dpipe[0] & ~dpipe[1];
    cv   = viol & ~sub;
    thr  = hdb3 ? ZW'(EXZ_HDB3) : ZW'(EXZ_AMI);
    exz  = seen & ~mark & ((zc + ZW'(1)) == thr);
    evt_o = strb & ~dual & (cv | exz);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dpipe    <= '0;
      seen     <= 1'b0;
      last_pos <= 1'b0;
      zc       <= '0;
      data_o   <= 1'b0;
      neg_o    <= 1'b0;
      err_o    <= 1'b0;
    end else if (strb) begin
      if (dual) begin
        data_o <= rp ^ inv;
        neg_o  <= rn ^ inv;
        err_o  <= 1'b0;
      end else begin
        // the oldest slot is the B of a B00V and is dropped on substitution
        data_o <= (dpipe[STG-1] & ~sub) ^ inv;
        neg_o  <= 1'b0;
        err_o  <= cv | exz;
        dpipe  <= {dpipe[STG-2:0], mark & ~sub};
        if (mark) begin
          seen     <= 1'b1;
          last_pos <= rp;
          zc       <= '0;
        end else if (seen && zc < thr) begin
          zc <= zc + ZW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lc_err_counter.sv
module lc_err_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic             latch,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] hold_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o  <= '0;
      hold_o <= '0;
    end else if (latch) begin
      hold_o <= cnt_o;
      cnt_o  <= evt ? CNT_W'(1) : '0;
    end else if (evt && cnt_o != '1) begin
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/line_codec.sv
module line_codec #(
  parameter int CNT_W    = 16,
  parameter int EXZ_HDB3 = 4,
  parameter int EXZ_AMI  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_clk,
  input  logic             cfg_fall_edge,
  input  logic             cfg_dual,
  input  logic             cfg_hdb3,
  input  logic             cfg_tx_inv,
  input  logic             cfg_rx_inv,
  input  logic             tx_data,
  input  logic             tx_neg,
  output logic             tx_pos_out,
  output logic             tx_neg_out,
  input  logic             rx_pos_in,
  input  logic             rx_neg_in,
  output logic             rx_data,
  output logic             rx_neg_out,
  output logic             rx_err,
  input  logic             cnt_latch,
  output logic [7:0]       cnt_lo,
  output logic [CNT_W-9:0] cnt_hi
);
  logic             strb, err_evt;
  logic [CNT_W-1:0] cnt_run, cnt_hold;

  lc_bit_strobe u_strb (
    .clk(clk), .rst(rst), .bit_clk(bit_clk),
    .fall_sel(cfg_fall_edge), .strb(strb)
  );

  lc_encoder u_enc (
    .clk(clk), .rst(rst), .strb(strb), .hdb3(cfg_hdb3), .dual(cfg_dual),
    .din(tx_data ^ cfg_tx_inv), .din_n(tx_neg ^ cfg_tx_inv),
    .pos_o(tx_pos_out), .neg_o(tx_neg_out)
  );

  lc_decoder #(.EXZ_HDB3(EXZ_HDB3), .EXZ_AMI(EXZ_AMI)) u_dec (
    .clk(clk), .rst(rst), .strb(strb), .hdb3(cfg_hdb3), .dual(cfg_dual),
    .inv(cfg_rx_inv), .rp(rx_pos_in), .rn(rx_neg_in),
    .data_o(rx_data), .neg_o(rx_neg_out), .err_o(rx_err), .evt_o(err_evt)
  );

  lc_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .evt(err_evt), .latch(cnt_latch),
    .cnt_o(cnt_run), .hold_o(cnt_hold)
  );

  assign cnt_lo = cnt_hold[7:0];
  assign cnt_hi = cnt_hold[CNT_W-1:8];
endmodule

// File: rtl/line_codec_checker.sv
module line_codec_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             strb,
  input logic             cfg_dual,
  input logic             tx_pos_out,
  input logic             tx_neg_out,
  input logic             rx_err,
  input logic             cnt_latch,
  input logic [7:0]       cnt_lo,
  input logic [CNT_W-9:0] cnt_hi,
  input logic [CNT_W-1:0] cnt_run
);
  assert_tx_rails_exclusive_R14: assert property (@(posedge clk) disable iff (rst)
    !(tx_pos_out && tx_neg_out));

  assert_tx_moves_on_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    !strb |=> $stable({tx_pos_out, tx_neg_out}));

  assert_no_err_dual_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_dual && strb) |=> !rx_err);

  assert_bytes_hold_R13: assert property (@(posedge clk) disable iff (rst)
    !cnt_latch |=> $stable({cnt_hi, cnt_lo}));

  assert_count_saturates_R12: assert property (@(posedge clk) disable iff (rst)
    (!cnt_latch && cnt_run == '1) |=> cnt_run == '1);
endmodule

bind line_codec line_codec_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .strb(strb), .cfg_dual(cfg_dual),
  .tx_pos_out(tx_pos_out), .tx_neg_out(tx_neg_out), .rx_err(rx_err),
  .cnt_latch(cnt_latch), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .cnt_run(cnt_run)
);

// File: tb/line_codec_test.sv
module line_codec_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_clk = 1'b0, cfg_fall_edge = 1'b0, cfg_dual = 1'b0, cfg_hdb3 = 1'b1;
  logic cfg_tx_inv = 1'b0, cfg_rx_inv = 1'b0, tx_data = 1'b0, tx_neg = 1'b0;
  logic rp_drv = 1'b0, rn_drv = 1'b0, lb = 1'b0, cnt_latch = 1'b0;
  logic tx_pos_out, tx_neg_out, rx_data, rx_neg_out, rx_err;
  logic rx_pos_in, rx_neg_in;
  logic [7:0] cnt_lo, cnt_hi;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  assign rx_pos_in = lb ? tx_pos_out : rp_drv;
  assign rx_neg_in = lb ? tx_neg_out : rn_drv;

  line_codec uut (
    .clk(clk), .rst(rst), .bit_clk(bit_clk), .cfg_fall_edge(cfg_fall_edge),
    .cfg_dual(cfg_dual), .cfg_hdb3(cfg_hdb3), .cfg_tx_inv(cfg_tx_inv),
    .cfg_rx_inv(cfg_rx_inv), .tx_data(tx_data), .tx_neg(tx_neg),
    .tx_pos_out(tx_pos_out), .tx_neg_out(tx_neg_out),
    .rx_pos_in(rx_pos_in), .rx_neg_in(rx_neg_in), .rx_data(rx_data),
    .rx_neg_out(rx_neg_out), .rx_err(rx_err), .cnt_latch(cnt_latch),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
  );

  // {tx bit, expected positive pulse, expected negative pulse} for the HDB3 stream
  localparam logic [2:0] VEC [24] = '{
    3'b110, 3'b000, 3'b000, 3'b000, 3'b010, 3'b101, 3'b110, 3'b001,
    3'b000, 3'b000, 3'b001, 3'b010, 3'b000, 3'b000, 3'b010, 3'b101,
    3'b110, 3'b001, 3'b000, 3'b000, 3'b001, 3'b000, 3'b000, 3'b000
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_clk = 1'b0; tx_data = 1'b0; tx_neg = 1'b0;
    rp_drv = 1'b0; rn_drv = 1'b0; cnt_latch = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // one bit period in rising-edge mode; returns after the strobe edge
  task automatic step(input logic d, input logic n, input logic p_rx, input logic n_rx);
    @(negedge clk);
    tx_data = d; tx_neg = n; rp_drv = p_rx; rn_drv = n_rx; bit_clk = 1'b1;
    @(negedge clk);
    bit_clk = 1'b0;
  endtask

  task automatic latch_cnt();
    @(negedge clk); cnt_latch = 1'b1;
    @(negedge clk); cnt_latch = 1'b0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // reset state
    do_reset();
    @(negedge clk);
    chk("reset tx", {14'd0, tx_pos_out, tx_neg_out}, 16'd0);
    chk("reset rx", {13'd0, rx_data, rx_neg_out, rx_err}, 16'd0);
    chk("reset cnt R13", {cnt_hi, cnt_lo}, 16'd0);

    // vector walk: HDB3 encode (R3) looped back into the decoder (R6)
    lb = 1'b1; cfg_hdb3 = 1'b1; cfg_dual = 1'b0;
    for (int j = 0; j < 24; j++) begin
      step(VEC[j][2], 1'b0, 1'b0, 1'b0);
      if (j >= 3) chk("R3 line symbol", {14'd0, tx_pos_out, tx_neg_out}, {14'd0, VEC[j-3][1:0]});
      else        chk("R3 pipe fill", {14'd0, tx_pos_out, tx_neg_out}, 16'd0);
      if (j >= 7) chk("R6 loop data", {15'd0, rx_data}, {15'd0, VEC[j-7][2]});
      chk("R9 no false error", {15'd0, rx_err}, 16'd0);
      chk("R14 rails", {15'd0, tx_pos_out & tx_neg_out}, 16'd0);
    end
    latch_cnt();
    chk("R12 clean stream count", {cnt_hi, cnt_lo}, 16'd0);
    lb = 1'b0;

    // R2 AMI: alternating marks, no zero substitution
    cfg_hdb3 = 1'b0;
    do_reset();
    begin
      logic [9:0] bits = 10'b0000000111; // bit i at index i
      logic [1:0] exp [10] = '{2'b00, 2'b00, 2'b00, 2'b10, 2'b01, 2'b10,
                               2'b00, 2'b00, 2'b00, 2'b00};
      for (int j = 0; j < 10; j++) begin
        step(bits[j], 1'b0, 1'b0, 1'b0);
        chk("R2 AMI symbol", {14'd0, tx_pos_out, tx_neg_out}, {14'd0, exp[j]});
      end
    end

    // R1 dual-rail bypass, R4 transmit inversion
    cfg_dual = 1'b1;
    step(1'b1, 1'b0, 1'b0, 1'b0); chk("R1 positive", {14'd0, tx_pos_out, tx_neg_out}, 16'd2);
    step(1'b0, 1'b1, 1'b0, 1'b0); chk("R1 negative", {14'd0, tx_pos_out, tx_neg_out}, 16'd1);
    step(1'b1, 1'b1, 1'b0, 1'b0); chk("R1 both high space", {14'd0, tx_pos_out, tx_neg_out}, 16'd0);
    cfg_tx_inv = 1'b1;
    step(1'b0, 1'b1, 1'b0, 1'b0); chk("R4 inverted positive", {14'd0, tx_pos_out, tx_neg_out}, 16'd2);
    step(1'b0, 1'b0, 1'b0, 1'b0); chk("R4 inverted space", {14'd0, tx_pos_out, tx_neg_out}, 16'd0);
    cfg_tx_inv = 1'b0;

    // R5 falling-edge strobe
    @(negedge clk); cfg_fall_edge = 1'b1;
    @(negedge clk); tx_data = 1'b1; tx_neg = 1'b0; bit_clk = 1'b1;
    @(negedge clk);
    chk("R5 rising edge ignored", {14'd0, tx_pos_out, tx_neg_out}, 16'd0);
    bit_clk = 1'b0;
    @(negedge clk);
    chk("R5 falling edge strobes", {14'd0, tx_pos_out, tx_neg_out}, 16'd2);
    cfg_fall_edge = 1'b0;

    // R10 dual-rail receive, R11 receive inversion
    step(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R10 dual rx pos", {14'd0, rx_data, rx_neg_out}, 16'd2);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R10 no error in dual", {15'd0, rx_err}, 16'd0);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R10 dual rx neg", {14'd0, rx_data, rx_neg_out}, 16'd1);
    cfg_rx_inv = 1'b1;
    step(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R11 inverted rx", {14'd0, rx_data, rx_neg_out}, 16'd1);
    cfg_rx_inv = 1'b0;
    cfg_dual = 1'b0;

    // R7 AMI bipolar violation
    cfg_hdb3 = 1'b0;
    do_reset();
    step(0, 0, 1, 0); chk("R7 first mark", {15'd0, rx_err}, 16'd0);
    step(0, 0, 0, 1); chk("R7 alternate", {15'd0, rx_err}, 16'd0);
    step(0, 0, 1, 0); chk("R7 alternate", {15'd0, rx_err}, 16'd0);
    step(0, 0, 1, 0); chk("R7 violation flagged", {15'd0, rx_err}, 16'd1);
    step(0, 0, 0, 1); chk("R10 flag lasts one bit", {15'd0, rx_err}, 16'd0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0); chk("R7 violation decodes as 1", {15'd0, rx_data}, 16'd1);
    latch_cnt();
    chk("R12 one event counted", {cnt_hi, cnt_lo}, 16'd1);

    // R8 HDB3 substitution versus code violation, R6 zero restore
    cfg_hdb3 = 1'b1;
    do_reset();
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    step(0, 0, 1, 0); chk("R8 substitution not an error", {15'd0, rx_err}, 16'd0);
    chk("R6 B slot restored", {15'd0, rx_data}, 16'd0);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1); chk("R8 code violation", {15'd0, rx_err}, 16'd1);
    step(0, 0, 1, 0); chk("R8 flag cleared", {15'd0, rx_err}, 16'd0);
    chk("R6 V slot restored", {15'd0, rx_data}, 16'd0);
    step(0, 0, 0, 0); chk("R6 mark after substitution", {15'd0, rx_data}, 16'd1);

    // R9 excess zeros, HDB3 threshold 4
    do_reset();
    step(0, 0, 1, 0);
    for (int j = 1; j <= 5; j++) begin
      step(0, 0, 0, 0);
      chk("R9 HDB3 zero run", {15'd0, rx_err}, (j == 4) ? 16'd1 : 16'd0);
    end
    // AMI threshold 16
    cfg_hdb3 = 1'b0;
    do_reset();
    step(0, 0, 1, 0);
    for (int j = 1; j <= 17; j++) begin
      step(0, 0, 0, 0);
      if (j >= 15) chk("R9 AMI zero run", {15'd0, rx_err}, (j == 16) ? 16'd1 : 16'd0);
    end

    // R12 saturation: constant positive marks violate on every strobe
    do_reset();
    @(negedge clk); rp_drv = 1'b1; rn_drv = 1'b0;
    for (int j = 0; j < 65540; j++) begin
      @(negedge clk); bit_clk = 1'b1;
      @(negedge clk); bit_clk = 1'b0;
    end
    latch_cnt();
    chk("R12 saturated count", {cnt_hi, cnt_lo}, 16'hFFFF);
    latch_cnt();
    chk("R13 latch cleared count", {cnt_hi, cnt_lo}, 16'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule